// File: doc/BRIEF.md
# DDR2 Refresh Sequencer

This block keeps a DDR2 SDRAM refreshed on time. A free-running cycle counter marks each elapsed refresh interval and adds one unit to an internal refresh debt. The interval is a parameter in clock cycles. While the `hot_i` input is high the interval is divided by a power of two (halved by default), because a hot device has to be refreshed twice as often.

The main command path owns the command bus while `main_gnt_o` is high. When refresh is owed, the sequencer lets the main path keep the bus as long as it asks for it through `main_req_i`. Only a bounded number of refreshes can be deferred this way. Once the debt reaches that bound, the sequencer takes the bus regardless of `main_req_i`.

When the sequencer takes the bus, it first drops the grant and drives one NOP. It then closes all banks with a precharge-all, waits the precharge time and issues REFRESH. The precharge and its wait are skipped when `banks_idle_i` reports every bank closed. After a REFRESH the sequencer holds the bus for the full refresh cycle time. It then issues a further REFRESH directly if more are owed and the bus may be kept, or it returns the grant. CKE is held high throughout.

Top module: `ddr2_refresh_sequencer`

## Requirements
- R1: Out of reset the block grants the bus (`main_gnt_o`=1), is not busy, drives a NOP and holds CKE high.
- R2: With `hot_i` low and the bus free, REFRESH commands follow one another every `REF_INT_CYC` cycles in steady state.
- R3: With `hot_i` high, the steady-state spacing between REFRESH commands is `REF_INT_CYC >> HOT_SHIFT` cycles.
- R4: While `main_req_i` is high, refresh is deferred until `MAX_POSTPONE` intervals are owed. The bus is then taken, and the grant stays high until that point.
- R5: `main_gnt_o` is always the inverse of `busy_o` and is high only while a NOP is driven. The grant falls exactly one cycle before the first command of a refresh sequence, and that cycle carries a NOP.
- R6: If `banks_idle_i` is low when the bus is taken, a PRECHARGE with A10=1 is issued. REFRESH follows exactly `T_RP_CYC` cycles later. A10 is 1 only on that PRECHARGE.
- R7: If `banks_idle_i` is high when the bus is taken, REFRESH is issued in the cycle after the grant falls and no PRECHARGE is sent.
- R8: Two REFRESH commands are at least `T_RFC_CYC` cycles apart. Owed refreshes drain back to back at exactly `T_RFC_CYC` spacing. The grant returns exactly `T_RFC_CYC` cycles after the last REFRESH.
- R9: The command fields {CS#,RAS#,CAS#,WE#} take only three codes: NOP=0111, PRECHARGE=0010, REFRESH=0001.
- R10: `cke_o` is 1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hot_i | input | 1 | Case temperature above the derating limit |
| banks_idle_i | input | 1 | All banks are closed |
| main_req_i | input | 1 | Main command path wants the bus |
| main_gnt_o | output | 1 | Main command path owns the bus |
| busy_o | output | 1 | Refresh sequence in progress |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | Address bit 10, all-bank select on precharge |
| cke_o | output | 1 | Clock enable |

## Verification
The assertions check on every cycle the behaviours that can be seen at the command bus:

- only the three command codes appear;
- the grant is the inverse of busy, and a granted cycle carries a NOP;
- A10 is high on precharge;
- every sequencer command follows at least one ungranted cycle;
- the minimum precharge-to-refresh and refresh-to-refresh gaps are kept, and the grant never returns early.

Only the bench scenarios can show the exact refresh periods under normal and hot conditions, the deferral limit under a held request, the skipped precharge when the banks are idle, and the count and exact spacing of a back-to-back drain.

// File: rtl/refsq_pkg.sv
package refsq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TAKE,
      ST_PRE,
      ST_WRP,
      ST_REF,
      ST_WRFC
   } seq_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic a10;
   } cmd_bus_t;

   localparam cmd_bus_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
   localparam cmd_bus_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
   localparam cmd_bus_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

   function automatic cmd_bus_t encode_cmd(seq_state_e st);
      case (st)
         ST_PRE:  return CMD_PREA;
         ST_REF:  return CMD_REF;
         default: return CMD_NOP;
      endcase
   endfunction

endpackage

// File: rtl/refsq_interval.sv
module refsq_interval #(
   parameter int unsigned REF_INT_CYC = 976,
   parameter int unsigned HOT_SHIFT   = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hot_i,
   output logic tick_o
);
   localparam int unsigned CW      = $clog2(REF_INT_CYC + 1);
   localparam int unsigned HOT_INT = REF_INT_CYC >> HOT_SHIFT;
   localparam logic [CW-1:0] LAST_NORM = CW'(REF_INT_CYC - 1);
   localparam logic [CW-1:0] LAST_HOT  = CW'(HOT_INT - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_w;

   assign last_w = hot_i ? LAST_HOT : LAST_NORM;
   // A counter already past a newly shortened limit wraps at once.
   assign tick_o = (cnt_q >= last_w);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/refsq_debt.sv
module refsq_debt #(
   parameter int unsigned MAX_POSTPONE = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic ref_i,
   output logic owed_o,
   output logic forced_o
);
   localparam int unsigned CAP = 2 * MAX_POSTPONE;
   localparam int unsigned DW  = $clog2(CAP + 1);
   localparam logic [DW-1:0] CAP_V   = DW'(CAP);
   localparam logic [DW-1:0] FORCE_V = DW'(MAX_POSTPONE);

   logic [DW-1:0] debt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         debt_q <= '0;
      end else begin
         case ({tick_i, ref_i})
            2'b10:   if (debt_q != CAP_V) debt_q <= debt_q + 1'b1;
            2'b01:   if (debt_q != '0) debt_q <= debt_q - 1'b1;
            default: debt_q <= debt_q;
         endcase
      end
   end

   assign owed_o   = (debt_q != '0);
   assign forced_o = (debt_q >= FORCE_V);
endmodule

// File: rtl/refsq_fsm.sv
module refsq_fsm
   import refsq_pkg::*;
#(
   parameter int unsigned T_RP_CYC  = 2,
   parameter int unsigned T_RFC_CYC = 16
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       owed_i,
   input  logic       forced_i,
   input  logic       main_req_i,
   input  logic       banks_idle_i,
   output seq_state_e state_o,
   output logic       ref_o
);
   localparam int unsigned WAIT_MAX = (T_RP_CYC > T_RFC_CYC) ? T_RP_CYC : T_RFC_CYC;
   localparam int unsigned WW       = $clog2(WAIT_MAX + 1);
   localparam logic [WW-1:0] RP_LOAD  = WW'(T_RP_CYC - 2);
   localparam logic [WW-1:0] RFC_LOAD = WW'(T_RFC_CYC - 2);

   seq_state_e    state_q, state_d;
   logic [WW-1:0] wait_q;
   logic          go_w;

   assign go_w = owed_i && (!main_req_i || forced_i);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (go_w) state_d = ST_TAKE;
         ST_TAKE: state_d = banks_idle_i ? ST_REF : ST_PRE;
         ST_PRE:  state_d = ST_WRP;
         ST_WRP:  if (wait_q == '0) state_d = ST_REF;
         ST_REF:  state_d = ST_WRFC;
         ST_WRFC: if (wait_q == '0) state_d = go_w ? ST_REF : ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         wait_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_PRE) begin
            wait_q <= RP_LOAD;
         end else if (state_q == ST_REF) begin
            wait_q <= RFC_LOAD;
         end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
         end
      end
   end

   assign state_o = state_q;
   assign ref_o   = (state_q == ST_REF);
endmodule

// File: rtl/refsq_cmd_out.sv
module refsq_cmd_out
   import refsq_pkg::*;
#(
   parameter bit REG_CMD = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  seq_state_e state_i,
   output cmd_bus_t   cmd_o,
   output logic       gnt_o,
   output logic       busy_o
);
   cmd_bus_t cmd_w;
   logic     gnt_w;

   assign cmd_w = encode_cmd(state_i);
   assign gnt_w = (state_i == ST_IDLE);

   generate
      if (REG_CMD) begin : g_reg
         cmd_bus_t cmd_q;
         logic     gnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cmd_q <= CMD_NOP;
               gnt_q <= 1'b1;
            end else begin
               cmd_q <= cmd_w;
               gnt_q <= gnt_w;
            end
         end
         assign cmd_o  = cmd_q;
         assign gnt_o  = gnt_q;
         assign busy_o = !gnt_q;
      end else begin : g_comb
         assign cmd_o  = cmd_w;
         assign gnt_o  = gnt_w;
         assign busy_o = !gnt_w;
      end
   endgenerate
endmodule

// File: rtl/ddr2_refresh_sequencer.sv
module ddr2_refresh_sequencer
   import refsq_pkg::*;
#(
   parameter int unsigned REF_INT_CYC  = 976,
   parameter int unsigned HOT_SHIFT    = 1,
   parameter int unsigned T_RP_CYC     = 2,
   parameter int unsigned T_RFC_CYC    = 16,
   parameter int unsigned MAX_POSTPONE = 8,
   parameter bit          REG_CMD      = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hot_i,
   input  logic banks_idle_i,
   input  logic main_req_i,
   output logic main_gnt_o,
   output logic busy_o,
   output logic cs_n_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic we_n_o,
   output logic a10_o,
   output logic cke_o
);
   localparam int unsigned HOT_INT = REF_INT_CYC >> HOT_SHIFT;

   initial begin
      assert (T_RP_CYC >= 2) else $error("T_RP_CYC must be at least 2");
      assert (T_RFC_CYC >= 2) else $error("T_RFC_CYC must be at least 2");
      assert (MAX_POSTPONE >= 1) else $error("MAX_POSTPONE must be at least 1");
      assert (HOT_INT > T_RP_CYC + T_RFC_CYC + 4)
         else $error("derated interval too short for one refresh sequence");
   end

   logic       tick_w, owed_w, forced_w, ref_w;
   seq_state_e state_w;
   cmd_bus_t   cmd_w;

   refsq_interval #(.REF_INT_CYC(REF_INT_CYC), .HOT_SHIFT(HOT_SHIFT)) u_int (
      .clk_i (clk_i), .rst_ni(rst_ni), .hot_i(hot_i), .tick_o(tick_w)
   );

   refsq_debt #(.MAX_POSTPONE(MAX_POSTPONE)) u_debt (
      .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .ref_i(ref_w),
      .owed_o(owed_w), .forced_o(forced_w)
   );

   refsq_fsm #(.T_RP_CYC(T_RP_CYC), .T_RFC_CYC(T_RFC_CYC)) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .owed_i      (owed_w),
      .forced_i    (forced_w),
      .main_req_i  (main_req_i),
      .banks_idle_i(banks_idle_i),
      .state_o     (state_w),
      .ref_o       (ref_w)
   );

   refsq_cmd_out #(.REG_CMD(REG_CMD)) u_out (
      .clk_i (clk_i), .rst_ni(rst_ni), .state_i(state_w),
      .cmd_o (cmd_w), .gnt_o(main_gnt_o), .busy_o(busy_o)
   );

   assign cs_n_o  = cmd_w.cs_n;
   assign ras_n_o = cmd_w.ras_n;
   assign cas_n_o = cmd_w.cas_n;
   assign we_n_o  = cmd_w.we_n;
   assign a10_o   = cmd_w.a10;
   assign cke_o   = 1'b1;
endmodule

// File: rtl/refsq_checker.sv
module refsq_checker #(
   parameter int unsigned T_RP_CYC  = 2,
   parameter int unsigned T_RFC_CYC = 16
) (
   input logic clk_i,
   input logic rst_ni,
   input logic main_gnt_o,
   input logic busy_o,
   input logic cs_n_o,
   input logic ras_n_o,
   input logic cas_n_o,
   input logic we_n_o,
   input logic a10_o
);
   localparam int unsigned CAP = T_RP_CYC + T_RFC_CYC + 2;
   localparam int unsigned CW  = $clog2(CAP + 1);
   localparam logic [CW-1:0] CAP_V = CW'(CAP);
   localparam logic [CW-1:0] RP_V  = CW'(T_RP_CYC);
   localparam logic [CW-1:0] RFC_V = CW'(T_RFC_CYC);

   logic [3:0] code;
   logic       is_nop, is_pre, is_ref;
   logic [CW-1:0] since_ref, since_pre;
   logic       seen_ref, pre_pend;

   assign code   = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
   assign is_nop = (code == 4'b0111);
   assign is_pre = (code == 4'b0010);
   assign is_ref = (code == 4'b0001);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         since_ref <= '0;
         since_pre <= '0;
         seen_ref  <= 1'b0;
         pre_pend  <= 1'b0;
      end else begin
         if (is_ref) begin
            since_ref <= CW'(1);
            seen_ref  <= 1'b1;
            pre_pend  <= 1'b0;
         end else if (since_ref != CAP_V) begin
            since_ref <= since_ref + 1'b1;
         end
         if (is_pre) begin
            since_pre <= CW'(1);
            pre_pend  <= 1'b1;
         end else if (since_pre != CAP_V) begin
            since_pre <= since_pre + 1'b1;
         end
      end
   end

   // R9: only the three legal command codes appear
   p_legal_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_nop || is_pre || is_ref);

   // R5: grant and busy are complementary
   p_gnt_not_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      main_gnt_o != busy_o);

   // R5: a granted cycle carries only a NOP from this block
   p_nop_when_granted_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      main_gnt_o |-> is_nop);

   // R5: every sequencer command follows an ungranted cycle
   p_take_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_pre || is_ref) |-> !$past(main_gnt_o));

   // R6: precharge selects all banks
   p_prea_a10_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_pre |-> a10_o);

   // R6: precharge-to-refresh gap
   p_rp_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_ref && pre_pend) |-> (since_pre >= RP_V));

   // R8: refresh-to-refresh gap
   p_rfc_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_ref && seen_ref) |-> (since_ref >= RFC_V));

   // R8: bus returned only after the refresh cycle time
   p_gnt_after_rfc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(main_gnt_o) && seen_ref) |-> (since_ref >= RFC_V));
endmodule

bind ddr2_refresh_sequencer refsq_checker #(
   .T_RP_CYC (T_RP_CYC),
   .T_RFC_CYC(T_RFC_CYC)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .main_gnt_o(main_gnt_o),
   .busy_o    (busy_o),
   .cs_n_o    (cs_n_o),
   .ras_n_o   (ras_n_o),
   .cas_n_o   (cas_n_o),
   .we_n_o    (we_n_o),
   .a10_o     (a10_o)
);

// File: tb/sim_ddr2_refresh_sequencer.sv
`timescale 1ns/1ps
module sim_ddr2_refresh_sequencer;
   localparam int INT  = 64;
   localparam int SHF  = 1;
   localparam int RP   = 3;
   localparam int RFC  = 9;
   localparam int MAXP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hot = 1'b0, idle = 1'b0, req = 1'b0;
   logic gnt, busy, cs_n, ras_n, cas_n, we_n, a10, cke;

   always #4 clk = ~clk;

   ddr2_refresh_sequencer #(
      .REF_INT_CYC(INT), .HOT_SHIFT(SHF), .T_RP_CYC(RP),
      .T_RFC_CYC(RFC), .MAX_POSTPONE(MAXP), .REG_CMD(1'b0)
   ) u0 (
      .clk_i(clk), .rst_ni(rst_n), .hot_i(hot), .banks_idle_i(idle),
      .main_req_i(req), .main_gnt_o(gnt), .busy_o(busy), .cs_n_o(cs_n),
      .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .a10_o(a10), .cke_o(cke)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ref_count = 0;
   int gnt_low_cnt = 0;
   int last_ref = -1, last_pre = -1, last_gnt_hi = 0;
   bit pre_pend = 0, prev_gnt = 1;
   int exp_gap = 0;
   string gap_req = "R2";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req_tag, act, exp, cyc);
      end
   endtask

   // Monitor samples away from the active edge.
   always @(negedge clk) begin
      if (!rst_n) begin
         last_ref = -1; last_pre = -1; last_gnt_hi = cyc;
         pre_pend = 0; prev_gnt = 1;
      end else begin
         automatic bit is_nop = {cs_n, ras_n, cas_n, we_n} == 4'b0111;
         automatic bit is_pre = {cs_n, ras_n, cas_n, we_n} == 4'b0010;
         automatic bit is_ref = {cs_n, ras_n, cas_n, we_n} == 4'b0001;
         chk(is_nop || is_pre || is_ref, "R9", {cs_n, ras_n, cas_n, we_n}, 7);
         chk(cke == 1'b1, "R10", cke, 1);
         chk(gnt != busy, "R5", gnt, !busy);
         chk(a10 == is_pre, "R6", a10, is_pre);
         if (!gnt) gnt_low_cnt++;
         if (is_pre) begin
            chk(cyc - last_gnt_hi == 2, "R5", cyc - last_gnt_hi, 2);
            chk(idle == 1'b0, "R7", idle, 0);
            pre_pend = 1; last_pre = cyc;
         end
         if (is_ref) begin
            if (pre_pend) begin
               chk(cyc - last_pre == RP, "R6", cyc - last_pre, RP);
            end else if (last_gnt_hi == cyc - 2) begin
               chk(idle == 1'b1, "R7", idle, 1);
            end else if (last_ref >= 0 && last_gnt_hi < last_ref) begin
               chk(cyc - last_ref == RFC, "R8", cyc - last_ref, RFC);
            end
            if (last_ref >= 0) chk(cyc - last_ref >= RFC, "R8", cyc - last_ref, RFC);
            if (exp_gap != 0 && last_ref >= 0 && last_gnt_hi > last_ref)
               chk(cyc - last_ref == exp_gap, gap_req, cyc - last_ref, exp_gap);
            ref_count++; last_ref = cyc; pre_pend = 0;
         end
         if (gnt) begin
            if (!prev_gnt && last_ref >= 0 && last_ref > last_gnt_hi)
               chk(cyc - last_ref == RFC, "R8", cyc - last_ref, RFC);
            last_gnt_hi = cyc;
         end
         prev_gnt = gnt;
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_refs(input int n);
      int target = ref_count + n;
      while (ref_count < target) @(posedge clk);
   endtask

   bit done = 0;

   initial begin
      int n0, c0;
      // R1: reset state
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(gnt == 1'b1, "R1", gnt, 1);
      chk(busy == 1'b0, "R1", busy, 0);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", {cs_n, ras_n, cas_n, we_n}, 7);
      chk(cke == 1'b1, "R1", cke, 1);
      rst_n = 1'b1;

      // R2: normal temperature period, banks open
      wait_refs(1);
      gap_req = "R2"; exp_gap = INT;
      n0 = ref_count; c0 = cyc;
      wait_refs(4);
      chk(ref_count - n0 == 4 && cyc - c0 < 4 * INT + 4, "R2", cyc - c0, 4 * INT);

      // R3: hot period
      exp_gap = 0; hot = 1'b1;
      wait_refs(2);
      gap_req = "R3"; exp_gap = INT >> SHF;
      wait_refs(4);

      // R7: idle banks skip the precharge
      exp_gap = 0; hot = 1'b0; idle = 1'b1;
      wait_refs(2);
      gap_req = "R7"; exp_gap = INT;
      wait_refs(3);

      // R4: deferral under a held request
      exp_gap = 0; idle = 1'b0; req = 1'b1;
      do_reset();
      n0 = ref_count; gnt_low_cnt = 0;
      repeat (MAXP * INT - 6) @(posedge clk);
      @(negedge clk);
      chk(ref_count == n0, "R4", ref_count - n0, 0);
      chk(gnt_low_cnt == 0, "R4", gnt_low_cnt, 0);
      repeat (RP + 20) @(posedge clk);
      @(negedge clk);
      chk(ref_count - n0 == 1, "R4", ref_count - n0, 1);
      gap_req = "R4"; exp_gap = INT;
      wait_refs(2);

      // R8: drain of the remaining debt back to back
      repeat (RFC + 3) @(posedge clk);
      exp_gap = 0;
      n0 = ref_count;
      req = 1'b0;
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk(ref_count - n0 == MAXP - 1, "R8", ref_count - n0, MAXP - 1);
      chk(gnt == 1'b1, "R8", gnt, 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule